// File: doc/BRIEF.md
# Double-Rate 7-to-2 Transmit Gearbox

This block sits at the transmit end of a source-synchronous serial link and runs entirely in the serial clock domain. The serial clock runs at three and a half times the parallel word rate. Each lane takes a 7-bit parallel word and emits one 2-bit pair per serial clock cycle. The pair feeds a double-data-rate output register: bit 1 is sent on the rising edge and bit 0 on the falling edge. Two words make a 14-bit group, and that group leaves as seven pairs. Every second word therefore starts in the middle of a pair. Several data lanes share one gearbox controller and move in lock-step. A further lane carries a fixed pattern and forms the forwarded clock.

Words enter through a valid/ready stream that carries all data lanes side by side. A word is taken only in a cycle where `in_valid` and `in_ready` are both high. The source must hold its word until it is taken. `in_ready` falls while a full group is waiting for the pairs in flight to finish, and it stays low until that group moves into the shifter. The output side has no back-pressure. `out_valid` marks the cycles in which the pairs carry group data. At the nominal rate of two words every seven serial cycles, it stays high without a break.

Top module: `tx71_gearbox`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0, every data pair and `clk_pair` are 0, and `in_ready` is 1.
- R2: After two words have been taken and are waiting, `in_ready` is 0 until those two words move into the shifter.
- R3: Each group is sent MSB-first. Bit 6 of the first word of each lane appears as bit 1 (rising half) of the first pair of that group.
- R4: In the fourth pair of a group, bit 1 carries bit 0 of the first word and bit 0 (falling half) carries bit 6 of the second word. The remaining pairs follow the second word down to its bit 0.
- R5: A group that is complete when the previous group's last pair is out continues with no gap. A run of N back-to-back groups keeps `out_valid` high for exactly 7·N cycles.
- R6: Every group on `clk_pair` is the sequence 11, 00, 01, 11, 10, 00, 11, which is the pattern 1100011 repeated twice. Its first pair coincides with the first pair of the data lanes.
- R7: When no full group is waiting at the end of a group, `out_valid` drops and all pairs read 0 until the next full group is loaded.
- R8: Lane l takes its word from `in_data[7l+6:7l]` and drives `out_pairs[2l+1:2l]`. All lanes share the same timing.
- R9: A word presented while `in_ready` is 0 is not taken and never appears in the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ser | input | 1 | Serial clock, 3.5x the word rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word stream valid |
| in_ready | output | 1 | Word stream ready |
| in_data | input | LANES*7 | One 7-bit word per lane, lane 0 in the low bits |
| out_valid | output | 1 | Pairs carry group data |
| out_pairs | output | LANES*2 | Per-lane pair, bit 1 rising half, bit 0 falling half |
| clk_pair | output | 2 | Forwarded-clock pair |

## Verification
A single group of walking-bit words, sent from idle, shows the bit order and where the mid-pair boundary falls. Its isolated run shows that the output stops after seven pairs. A back-to-back source stalls on `in_ready`. Substitute words are placed on the bus only while it stalls, so any word taken outside a handshake turns up in the scoreboard. The source then switches to the nominal 4/3-cycle cadence. That shows groups join seamlessly when words arrive just in time, and the lengths of the `out_valid` runs are checked against the number of groups sent.

// File: rtl/tx71_pkg.sv
package tx71_pkg;
  localparam int WORD_W     = 7;
  localparam int GROUP_W    = 2 * WORD_W;
  localparam int PAIRS      = GROUP_W / 2;
  localparam int LAST_PHASE = PAIRS - 1;
  localparam int PHASE_W    = $clog2(PAIRS);
  localparam logic [WORD_W-1:0] CLK_WORD = 7'b1100011;
endpackage

// File: rtl/tx71_gear_ctrl.sv
module tx71_gear_ctrl
  import tx71_pkg::*;
(
  input  logic clk_ser,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic accept,
  output logic slot_sel,
  output logic load,
  output logic step,
  output logic stop,
  output logic out_valid
);
  logic [1:0]         fill_q;
  logic [PHASE_W-1:0] phase_q;
  logic               run_q;
  logic               last;

  assign last      = (phase_q == PHASE_W'(LAST_PHASE));
  assign in_ready  = (fill_q != 2'd2);
  assign accept    = in_valid && in_ready;
  assign slot_sel  = fill_q[0];
  assign load      = (fill_q == 2'd2) && (!run_q || last);
  assign step      = run_q && !last;
  assign stop      = run_q && last && !load;
  assign out_valid = run_q;

  always_ff @(posedge clk_ser) begin
    if (!rst_n) begin
      fill_q  <= 2'd0;
      phase_q <= '0;
      run_q   <= 1'b0;
    end else begin
      if (load) begin
        fill_q  <= 2'd0;
        phase_q <= '0;
        run_q   <= 1'b1;
      end else begin
        if (accept) fill_q <= fill_q + 2'd1;
        if (step) phase_q <= phase_q + PHASE_W'(1);
        if (stop) begin
          phase_q <= '0;
          run_q   <= 1'b0;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_ser) disable iff (!rst_n)
    (!in_ready && !load) |=> !in_ready); // R2

  AST_PHASE_RANGE: assert property (@(posedge clk_ser) disable iff (!rst_n)
    phase_q <= PHASE_W'(LAST_PHASE)); // R5

  AST_CONTINUOUS: assert property (@(posedge clk_ser) disable iff (!rst_n)
    (run_q && !last) |=> (run_q && phase_q == PHASE_W'($past(phase_q) + PHASE_W'(1)))); // R5
endmodule

// File: rtl/tx71_lane.sv
module tx71_lane
  import tx71_pkg::*;
(
  input  logic              clk_ser,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              slot_sel,
  input  logic [WORD_W-1:0] word,
  input  logic              load,
  input  logic              step,
  input  logic              stop,
  output logic [1:0]        pair
);
  logic [WORD_W-1:0]  slot0_q, slot1_q;
  logic [GROUP_W-1:0] shift_q;
  logic [GROUP_W-1:0] group;
  logic [1:0]         pair_q;

  assign group = {slot0_q, slot1_q};
  assign pair  = pair_q;

  always_ff @(posedge clk_ser) begin
    if (!rst_n) begin
      slot0_q <= '0;
      slot1_q <= '0;
      shift_q <= '0;
      pair_q  <= 2'b00;
    end else begin
      if (accept) begin
        if (slot_sel) slot1_q <= word;
        else          slot0_q <= word;
      end
      if (load) begin
        pair_q  <= group[GROUP_W-1 -: 2];
        shift_q <= group << 2;
      end else if (step) begin
        pair_q  <= shift_q[GROUP_W-1 -: 2];
        shift_q <= shift_q << 2;
      end else if (stop) begin
        pair_q  <= 2'b00;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_ser) disable iff (!rst_n)
    !accept |=> ($stable(slot0_q) && $stable(slot1_q))); // R9
endmodule

// File: rtl/tx71_gearbox.sv
module tx71_gearbox
  import tx71_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk_ser,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*WORD_W-1:0] in_data,
  output logic                    out_valid,
  output logic [LANES*2-1:0]      out_pairs,
  output logic [1:0]              clk_pair
);
  logic accept, slot_sel, load, step, stop;

  tx71_gear_ctrl u_ctrl (
    .clk_ser   (clk_ser),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .accept    (accept),
    .slot_sel  (slot_sel),
    .load      (load),
    .step      (step),
    .stop      (stop),
    .out_valid (out_valid)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tx71_lane u_lane (
      .clk_ser  (clk_ser),
      .rst_n    (rst_n),
      .accept   (accept),
      .slot_sel (slot_sel),
      .word     (in_data[l*WORD_W +: WORD_W]),
      .load     (load),
      .step     (step),
      .stop     (stop),
      .pair     (out_pairs[l*2 +: 2])
    );
  end

  tx71_lane u_clk_lane (
    .clk_ser  (clk_ser),
    .rst_n    (rst_n),
    .accept   (accept),
    .slot_sel (slot_sel),
    .word     (CLK_WORD),
    .load     (load),
    .step     (step),
    .stop     (stop),
    .pair     (clk_pair)
  );

  AST_IDLE_ZERO: assert property (@(posedge clk_ser) disable iff (!rst_n)
    !out_valid |-> (out_pairs == '0 && clk_pair == 2'b00)); // R7

  AST_CLK_LEAD: assert property (@(posedge clk_ser) disable iff (!rst_n)
    load |=> (out_valid && clk_pair == 2'b11)); // R6
endmodule

// File: tb/tb_tx71_gearbox.sv
module tb_tx71_gearbox;
  import tx71_pkg::*;
  localparam int LANES = 4;
  localparam int DW    = LANES * WORD_W;

  logic          clk_ser = 1'b0;
  logic          rst_n   = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [LANES*2-1:0] out_pairs;
  logic [1:0]    clk_pair;

  typedef struct packed {
    logic [LANES*2-1:0] d;
    logic [1:0]         c;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad   = 0;
  int stalls = 0;
  int cur_run = 0;
  int last_run = 0;

  always #5 clk_ser = ~clk_ser;

  tx71_gearbox #(.LANES(LANES)) dut (
    .clk_ser(clk_ser), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_pairs(out_pairs), .clk_pair(clk_pair)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Driver side: queue the seven expected pairs of a group (R3, R4, R6, R8)
  task automatic push_group(input logic [DW-1:0] wa, input logic [DW-1:0] wb);
    logic [13:0] clkg;
    clkg = 14'b11000111100011;
    for (int k = 0; k < 7; k++) begin
      exp_t e;
      for (int l = 0; l < LANES; l++) begin
        logic [13:0] g;
        g = {wa[l*7 +: 7], wb[l*7 +: 7]};
        e.d[l*2 +: 2] = 2'((g >> (12 - 2*k)) & 14'd3);
      end
      e.c = 2'((clkg >> (12 - 2*k)) & 14'd3);
      exp_q.push_back(e);
    end
  endtask

  // Called at a negedge; returns at the negedge after acceptance. Junk while stalled (R9).
  task automatic send_word(input logic [DW-1:0] w);
    in_valid = 1'b1;
    forever begin
      if (in_ready) begin
        in_data = w;
        @(posedge clk_ser);
        @(negedge clk_ser);
        in_valid = 1'b0;
        break;
      end else begin
        in_data = ~w ^ 28'h5A5A5A5;
        stalls++;
        @(posedge clk_ser);
        @(negedge clk_ser);
      end
    end
  endtask

  function automatic logic [DW-1:0] mkword(input int n);
    logic [DW-1:0] w;
    for (int l = 0; l < LANES; l++) w[l*7 +: 7] = 7'((n * 37 + l * 53 + 11) ^ (n >> 1));
    return w;
  endfunction

  // Monitor: compare each valid pair against the scoreboard
  always @(negedge clk_ser) begin
    if (rst_n) begin
      if (out_valid) begin
        cur_run++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 R7 unexpected pair", 64'(out_pairs), 64'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(out_pairs == e.d, "R3 R4 R8 data pair", 64'(out_pairs), 64'(e.d));
          chk(clk_pair == e.c, "R6 clock pair", 64'(clk_pair), 64'(e.c));
        end
      end else if (cur_run > 0) begin
        last_run = cur_run;
        cur_run = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_ser);
    bad++;
    total++;
    $display("FAIL R5 watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] wa, wb;
    repeat (3) @(negedge clk_ser);
    chk(out_valid == 1'b0, "R1 valid in reset", 64'(out_valid), 64'h0);
    chk(out_pairs == '0 && clk_pair == 2'b00, "R1 pairs in reset", 64'({out_pairs, clk_pair}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk_ser);
    chk(in_ready == 1'b1, "R1 ready after reset", 64'(in_ready), 64'h1);
    chk(out_valid == 1'b0 && out_pairs == '0, "R1 idle after reset", 64'({out_valid, out_pairs}), 64'h0);

    // Walking-bit group from idle: order and mid-pair boundary (R3, R4)
    for (int l = 0; l < LANES; l++) begin
      wa[l*7 +: 7] = 7'h40 >> l;
      wb[l*7 +: 7] = 7'h01 << l;
    end
    push_group(wa, wb);
    send_word(wa);
    send_word(wb);
    chk(in_ready == 1'b0, "R2 ready low with two words held", 64'(in_ready), 64'h0);
    repeat (14) @(negedge clk_ser);
    chk(last_run == 7, "R5 single group run length", 64'(last_run), 64'd7);
    chk(out_valid == 1'b0 && out_pairs == '0 && clk_pair == 2'b00, "R7 zeros after drain",
        64'({out_valid, out_pairs, clk_pair}), 64'h0);

    // Back-to-back source with stalls and junk on stalled cycles (R2, R9, R5)
    for (int g = 0; g < 6; g++) begin
      wa = mkword(2*g);
      wb = mkword(2*g + 1);
      push_group(wa, wb);
      send_word(wa);
      send_word(wb);
    end
    repeat (20) @(negedge clk_ser);
    chk(stalls > 0, "R2 R9 back-pressure observed", 64'(stalls), 64'h1);
    chk(last_run == 42, "R5 back-to-back run length", 64'(last_run), 64'd42);
    chk(out_valid == 1'b0 && out_pairs == '0, "R7 zeros after burst", 64'({out_valid, out_pairs}), 64'h0);

    // Nominal 4/3 cadence (R5)
    for (int g = 0; g < 8; g++) begin
      wa = mkword(100 + 2*g);
      wb = mkword(101 + 2*g);
      push_group(wa, wb);
      send_word(wa);
      repeat (3) @(negedge clk_ser);
      send_word(wb);
      repeat (2) @(negedge clk_ser);
    end
    repeat (20) @(negedge clk_ser);
    chk(last_run == 56, "R5 cadence run length", 64'(last_run), 64'd56);
    chk(exp_q.size() == 0, "R8 all expected pairs seen", 64'(exp_q.size()), 64'h0);
    chk(clk_pair == 2'b00, "R7 clock lane idle", 64'(clk_pair), 64'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule